// File: doc/BRIEF.md
# Block Address Translation Lookup

This unit maps a 32-bit effective address to a physical address by searching a small set of block-mapping entries. Instruction fetches and data accesses use separate banks of entries, and each entry is a pair of 32-bit words. The upper word holds the effective block base, a block-length mask and the two mode-validity bits. The lower word holds the physical block base and the permission bits. A block can cover 128 KB or any power-of-two multiple of that up to 256 MB. The length mask decides which address bits inside the block pass through to the physical address.

A request presents the address, whether it is a fetch or a data access, and whether the requester runs in user or supervisor mode. The response arrives one cycle later with a hit flag, the physical address and read/write permission. The lowest-numbered matching entry is used. If no entry matches, the effective address is stored in a fault-address register for the exception logic. When translation is switched off, the address passes straight through with full access. The entries are loaded through a simple word-write port.

Top module: `blkmap_xlate`

## Requirements
- R1: A request with `req_code`=1 searches only the code bank, and a request with `req_code`=0 searches only the data bank. An address mapped in one bank misses in the other.
- R2: An entry matches when ea[31:28] equals upper[31:28] and (ea[27:17] AND NOT mask) equals upper[27:17]. Here mask is upper[12:2] placed on bits 27..17.
- R3: An entry takes part only if it is valid for the current mode. Upper bit 1 enables it for supervisor (`req_user`=0) and upper bit 0 enables it for user (`req_user`=1).
- R4: On a hit, the physical address is lower[31:28] in bits 31..28, then ((ea[27:17] AND mask) OR lower[27:17]) in bits 27..17, then ea[16:0] unchanged.
- R5: Permission comes from lower[1:0]. 00 gives no access, 01 gives read only, and 10 or 11 give read and write. Write is never granted without read.
- R6: When several entries match, the lowest-numbered entry gives the result.
- R7: On a miss in translated mode, `rsp_hit`, `rsp_pa`, `rsp_rd` and `rsp_wr` are all 0, and `fault_addr` takes the effective address. At all other times `fault_addr` holds its value.
- R8: Translation is bypassed when a fetch arrives with `xlat_code_en`=0, or when `xlat_data_en`=0 for any request. In that case the response is a hit with `rsp_pa` equal to the effective address and both read and write granted.
- R9: The response appears with `rsp_valid`=1 in the cycle after `req_valid`=1. `rsp_valid` is 0 after a cycle without a request, and the response fields keep their values.
- R10: A write with `wr_en`=1 stores `wr_data` into one word chosen by `wr_addr`: bit 0 = 1 selects the lower word, bits 2:1 give the entry index, and bit 3 = 1 selects the code bank. A lookup in the same cycle as the write still sees the old contents, and later lookups see the new ones.
- R11: After reset, every entry word is zero, so every entry is invalid in translated mode. `rsp_valid` and `fault_addr` are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_addr | input | 4 | {bank, index[1:0], word} select for the write |
| wr_data | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_code | input | 1 | 1 = instruction fetch, 0 = data access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| xlat_code_en | input | 1 | Instruction translation enable |
| xlat_data_en | input | 1 | Data translation enable |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | Translation found, or bypassed |
| rsp_pa | output | 32 | Physical address |
| rsp_rd | output | 1 | Read allowed |
| rsp_wr | output | 1 | Write allowed |
| fault_addr | output | 32 | Last effective address that missed |

## Verification
An entry-word write and a lookup that hits that same entry can fall in the same clock cycle. The bench provokes this by clearing a data entry's lower word in the very cycle that a supervisor lookup of that entry's block is issued. The lookup must return the old mapping and read/write access. A second lookup right after must show the cleared word: a hit with no permission, the physical base gone and the offset kept. The miss path and the fault-address capture are judged in the same response: each missing vector must also leave its own address in `fault_addr`.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
   localparam int WORD_W  = 32;
   localparam int SEG_LO  = 28;
   localparam int BLK_LO  = 17;
   localparam int BLK_W   = SEG_LO - BLK_LO;
   localparam int LEN_LO  = 2;
   localparam int OFF_W   = BLK_LO;
   localparam int V_SUP   = 1;
   localparam int V_USR   = 0;
   localparam int P_RO    = 0;
   localparam int P_RW    = 1;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t upr;
      word_t lwr;
   } ent_t;
endpackage

// File: rtl/blkmap_regs.sv
module blkmap_regs #(
   parameter int N_ENT = 4,
   localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
   localparam int WA_W  = IDX_W + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [WA_W-1:0]       wr_addr,
   input  blkmap_pkg::word_t     wr_data,
   output blkmap_pkg::ent_t      code_ent [N_ENT],
   output blkmap_pkg::ent_t      data_ent [N_ENT]
);
   logic             wr_bank;
   logic             wr_low;
   logic [IDX_W-1:0] wr_idx;

   assign wr_bank = wr_addr[WA_W-1];
   assign wr_low  = wr_addr[0];
   assign wr_idx  = wr_addr[IDX_W:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ENT; i++) begin
            code_ent[i] <= '0;
            data_ent[i] <= '0;
         end
      end else if (wr_en) begin
         for (int i = 0; i < N_ENT; i++) begin
            if (wr_idx == IDX_W'(i)) begin
               if (wr_bank) begin
                  if (wr_low) code_ent[i].lwr <= wr_data;
                  else        code_ent[i].upr <= wr_data;
               end else begin
                  if (wr_low) data_ent[i].lwr <= wr_data;
                  else        data_ent[i].upr <= wr_data;
               end
            end
         end
      end
   end

   // R10
   entry_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_bank && !wr_low && wr_idx == '0) |=> (data_ent[0].upr == $past(wr_data)));
endmodule

// File: rtl/blkmap_match.sv
module blkmap_match #(
   parameter int N_ENT = 4
) (
   input  blkmap_pkg::ent_t  ent [N_ENT],
   input  blkmap_pkg::word_t ea,
   input  logic              user,
   output logic              hit,
   output blkmap_pkg::word_t pa,
   output logic              rd,
   output logic              wr
);
   import blkmap_pkg::*;

   logic [N_ENT-1:0] hv;
   logic [N_ENT-1:0] rd_e;
   logic [N_ENT-1:0] wr_e;
   word_t            pa_e [N_ENT];
   logic [N_ENT-1:0] unused_bits;

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      logic [BLK_W-1:0] msk;
      logic             seg_eq;
      logic             blk_eq;
      logic             mode_ok;

      assign msk     = ent[i].upr[LEN_LO +: BLK_W];
      assign seg_eq  = ea[WORD_W-1:SEG_LO] == ent[i].upr[WORD_W-1:SEG_LO];
      assign blk_eq  = (ea[SEG_LO-1:BLK_LO] & ~msk) == ent[i].upr[SEG_LO-1:BLK_LO];
      assign mode_ok = user ? ent[i].upr[V_USR] : ent[i].upr[V_SUP];
      assign hv[i]   = seg_eq && blk_eq && mode_ok;

      assign pa_e[i] = {ent[i].lwr[WORD_W-1:SEG_LO],
                        (ea[SEG_LO-1:BLK_LO] & msk) | ent[i].lwr[SEG_LO-1:BLK_LO],
                        ea[OFF_W-1:0]};
      assign wr_e[i] = ent[i].lwr[P_RW];
      assign rd_e[i] = ent[i].lwr[P_RW] | ent[i].lwr[P_RO];

      assign unused_bits[i] = ^{ent[i].upr[BLK_LO-1:LEN_LO+BLK_W],
                                ent[i].lwr[BLK_LO-1:P_RW+1]};
   end

   // scan downward so the lowest matching index is the last to assign
   always_comb begin
      hit = 1'b0;
      pa  = '0;
      rd  = 1'b0;
      wr  = 1'b0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (hv[i]) begin
            hit = 1'b1;
            pa  = pa_e[i];
            rd  = rd_e[i];
            wr  = wr_e[i];
         end
      end
   end
endmodule

// File: rtl/blkmap_xlate.sv
module blkmap_xlate #(
   parameter int N_ENT = 4,
   localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
   localparam int WA_W  = IDX_W + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [WA_W-1:0] wr_addr,
   input  logic [31:0]     wr_data,
   input  logic            req_valid,
   input  logic [31:0]     req_ea,
   input  logic            req_code,
   input  logic            req_user,
   input  logic            xlat_code_en,
   input  logic            xlat_data_en,
   output logic            rsp_valid,
   output logic            rsp_hit,
   output logic [31:0]     rsp_pa,
   output logic            rsp_rd,
   output logic            rsp_wr,
   output logic [31:0]     fault_addr
);
   import blkmap_pkg::*;

   if (N_ENT < 1 || N_ENT > 16) begin : g_bad_count
      $error("blkmap_xlate: N_ENT must be between 1 and 16");
   end
   if (WORD_W != 32) begin : g_bad_width
      $error("blkmap_xlate: field layout assumes 32-bit words");
   end

   ent_t  code_ent [N_ENT];
   ent_t  data_ent [N_ENT];
   ent_t  sel_ent  [N_ENT];
   logic  m_hit, m_rd, m_wr;
   word_t m_pa;
   logic  bypass;

   blkmap_regs #(.N_ENT(N_ENT)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .code_ent (code_ent),
      .data_ent (data_ent)
   );

   // one comparator set, fed by the bank the access type picks
   always_comb begin
      for (int i = 0; i < N_ENT; i++) begin
         sel_ent[i] = req_code ? code_ent[i] : data_ent[i];
      end
   end

   blkmap_match #(.N_ENT(N_ENT)) i_match (
      .ent  (sel_ent),
      .ea   (req_ea),
      .user (req_user),
      .hit  (m_hit),
      .pa   (m_pa),
      .rd   (m_rd),
      .wr   (m_wr)
   );

   assign bypass = (req_code && !xlat_code_en) || !xlat_data_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_pa     <= '0;
         rsp_rd     <= 1'b0;
         rsp_wr     <= 1'b0;
         fault_addr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            if (bypass) begin
               rsp_hit <= 1'b1;
               rsp_pa  <= req_ea;
               rsp_rd  <= 1'b1;
               rsp_wr  <= 1'b1;
            end else begin
               rsp_hit <= m_hit;
               rsp_pa  <= m_pa;
               rsp_rd  <= m_rd;
               rsp_wr  <= m_wr;
               if (!m_hit) fault_addr <= req_ea;
            end
         end
      end
   end

   // R9
   rsp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R9
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)));

   // R4
   offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_hit || rsp_pa[OFF_W-1:0] == $past(req_ea[OFF_W-1:0])));

   // R5
   write_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wr |-> rsp_rd);

   // R7
   fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_hit || fault_addr == $past(req_ea)));

   // R7
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && !rsp_rd && !rsp_wr));

   // R7
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(fault_addr));

   // R8
   bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && bypass) |=> (rsp_hit && rsp_rd && rsp_wr && rsp_pa == $past(req_ea)));
endmodule

// File: tb/test_blkmap_xlate.sv
`timescale 1ns/1ps
module test_blkmap_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_ea = '0;
   logic        req_code = 1'b0;
   logic        req_user = 1'b0;
   logic        xlat_code_en = 1'b1;
   logic        xlat_data_en = 1'b1;
   logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr;
   logic [31:0] rsp_pa, fault_addr;

   int total = 0;
   int bad   = 0;
   logic [31:0] exp_fault = '0;

   always #4 clk = ~clk;

   blkmap_xlate i_blkmap_xlate (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .req_valid(req_valid), .req_ea(req_ea), .req_code(req_code), .req_user(req_user),
      .xlat_code_en(xlat_code_en), .xlat_data_en(xlat_data_en),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
      .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .fault_addr(fault_addr)
   );

   // {code, user, ea[31:0], hit, pa[31:0], rd, wr}
   localparam int NV = 13;
   localparam logic [68:0] VEC [NV] = '{
      {1'b0, 1'b0, 32'h8000_1234, 1'b1, 32'h1000_1234, 1'b1, 1'b1}, // R6 sup: entry 0 over 2
      {1'b0, 1'b1, 32'h8000_1234, 1'b1, 32'h2000_1234, 1'b1, 1'b0}, // R3 R6 user: entry 1
      {1'b0, 1'b0, 32'h8001_FFFF, 1'b1, 32'h1001_FFFF, 1'b1, 1'b1}, // R2 top of 128K
      {1'b0, 1'b0, 32'h8002_0000, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R2 just past block
      {1'b0, 1'b0, 32'hCABC_DEF0, 1'b1, 32'h5ABC_DEF0, 1'b1, 1'b1}, // R4 256M block
      {1'b0, 1'b1, 32'hC000_0004, 1'b1, 32'h5000_0004, 1'b1, 1'b1}, // R5 perm 11
      {1'b1, 1'b0, 32'h8000_1234, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R1 code bank miss
      {1'b1, 1'b0, 32'h0000_0100, 1'b1, 32'h7FFE_0100, 1'b1, 1'b0}, // R4 base bits
      {1'b1, 1'b1, 32'h0000_0100, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R3 sup only
      {1'b1, 1'b1, 32'h4005_4321, 1'b1, 32'h900D_4321, 1'b1, 1'b1}, // R4 partial mask
      {1'b1, 1'b0, 32'h4008_0000, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R2 outside mask
      {1'b0, 1'b0, 32'h0000_0100, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R1 data bank miss
      {1'b1, 1'b0, 32'h4006_0000, 1'b1, 32'h900E_0000, 1'b1, 1'b1}  // R4 mask merge
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lookup(input logic code, input logic user, input logic [31:0] ea);
      @(negedge clk);
      req_valid = 1'b1; req_code = code; req_user = user; req_ea = ea;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string req, input logic hit, input logic [31:0] pa,
                             input logic rd, input logic wr, input logic [31:0] ea);
      chk({req, " valid"}, {31'b0, rsp_valid}, 32'd1);
      chk({req, " hit"}, {31'b0, rsp_hit}, {31'b0, hit});
      chk({req, " pa"}, rsp_pa, pa);
      chk({req, " perm"}, {30'b0, rsp_rd, rsp_wr}, {30'b0, rd, wr});
      if (!hit) exp_fault = ea;
      chk({req, " fault"}, fault_addr, exp_fault);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'd0);
      chk("R11 fault_addr", fault_addr, 32'd0);
      rst_n = 1'b1;
      lookup(1'b0, 1'b0, 32'h8000_1234);
      expect_rsp("R11 empty", 1'b0, 32'd0, 1'b0, 1'b0, 32'h8000_1234);
      // R9 idle cycle: strobe low, fields held
      @(negedge clk);
      chk("R9 idle valid", {31'b0, rsp_valid}, 32'd0);
      chk("R9 idle hold", {31'b0, rsp_hit}, 32'd0);

      // R10 load entries: {bank, idx, word}
      wr_word(4'h0, 32'h8000_0002); wr_word(4'h1, 32'h1000_0002);
      wr_word(4'h2, 32'h8000_0001); wr_word(4'h3, 32'h2000_0001);
      wr_word(4'h4, 32'h8000_0003); wr_word(4'h5, 32'h3000_0000);
      wr_word(4'h6, 32'hC000_1FFF); wr_word(4'h7, 32'h5000_0003);
      wr_word(4'h8, 32'h0000_0002); wr_word(4'h9, 32'h7FFE_0001);
      wr_word(4'hA, 32'h4000_000F); wr_word(4'hB, 32'h9008_0002);

      for (int v = 0; v < NV; v++) begin
         lookup(VEC[v][68], VEC[v][67], VEC[v][66:35]);
         expect_rsp($sformatf("R1-vec%0d R2 R4 R5", v), VEC[v][34], VEC[v][33:2],
                    VEC[v][1], VEC[v][0], VEC[v][66:35]);
      end

      // R8 bypass cases
      xlat_data_en = 1'b0;
      lookup(1'b0, 1'b0, 32'h8000_1234);
      expect_rsp("R8 data off", 1'b1, 32'h8000_1234, 1'b1, 1'b1, 32'h0);
      lookup(1'b1, 1'b1, 32'h1234_5678);
      expect_rsp("R8 data off fetch", 1'b1, 32'h1234_5678, 1'b1, 1'b1, 32'h0);
      xlat_data_en = 1'b1; xlat_code_en = 1'b0;
      lookup(1'b1, 1'b0, 32'h8000_1234);
      expect_rsp("R8 code off fetch", 1'b1, 32'h8000_1234, 1'b1, 1'b1, 32'h0);
      lookup(1'b0, 1'b0, 32'h8000_1234);
      expect_rsp("R8 code off data", 1'b1, 32'h1000_1234, 1'b1, 1'b1, 32'h0);
      xlat_code_en = 1'b1;

      // R10 write and lookup in the same cycle: old contents answer
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'h1; wr_data = 32'h0000_0000;
      req_valid = 1'b1; req_code = 1'b0; req_user = 1'b0; req_ea = 32'h8000_1234;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      expect_rsp("R10 same cycle", 1'b1, 32'h1000_1234, 1'b1, 1'b1, 32'h0);
      lookup(1'b0, 1'b0, 32'h8000_1234);
      expect_rsp("R10 R5 no access", 1'b1, 32'h0000_1234, 1'b0, 1'b0, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule